// File: doc/BRIEF.md
# SCSI Controller Command Register Model

This block models the host-visible register file of a SCSI protocol controller. A host reaches a bank of byte registers through a word-strided address: the byte index is taken from address bits [5:2], and everything above bit 5 or below bit 2 is ignored. Most indices hold a plain byte. Index 3 is a command port. Indices 4 to 7 and 9 to 15 are status or identification bytes that the host cannot overwrite. Reads are combinational and have no side effects.

A write to the command port is decoded from its low seven bits. A chip-reset command returns the whole block to its power-on state. A select-with-attention command does not run any bus phase. It reports at once that no target answered: it loads fixed status, interrupt-cause and sequence bytes and raises an interrupt line. That line stays high until a chip reset or a system reset clears it. A small separate window holds four 32-bit DMA control words that the host can read and write. The block carries no real bus signalling, FIFO or data movement.

Top module: `scsi_ctl_regs`

## Requirements
- R1: On system reset (`rst` high at a clock edge), every byte register reads 0x00 except index 14, which reads 0x04. The `irq` output is 0 and all four DMA words read 0.
- R2: The byte-register index is `reg_addr[5:2]`. Address bits [7:6] and [1:0] do not affect which register a read or write reaches.
- R3: A write to index 3 is a command, and only bits [6:0] of the data are decoded. For example, 0x82 acts as chip reset and 0xC2 acts as select with attention.
- R4: The commands 0x00 (no-op), 0x03 (bus reset) and 0x1A (set attention) change no register and do not change `irq`.
- R5: Command 0x02 (chip reset) restores every byte register and every DMA word to the R1 values and drops `irq`, effective at the next clock edge.
- R6: Command 0x42 (select with attention) loads index 4 with 0x1A, index 5 with 0x20 and index 6 with 0x04, and drives `irq` to 1 after the same clock edge.
- R7: Host writes to indices 4 to 7 and 9 to 15 are ignored. Index 3 stores nothing and always reads 0x00. Writes to indices 0, 1, 2 and 8 store the data byte.
- R8: Once `irq` is 1, it stays 1 until a chip-reset command or a system reset.
- R9: A command code outside the set {0x00, 0x02, 0x03, 0x1A, 0x42} (after masking bit 7) changes no register and does not change `irq`.
- R10: The DMA window holds four 32-bit read/write words indexed by `dma_addr[3:2]`. The other address bits are ignored, and a write is visible on `dma_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_wr | input | 1 | Byte-register write strobe |
| reg_addr | input | 8 | Byte-register address (index in bits [5:2]) |
| reg_wdata | input | 8 | Byte-register write data |
| reg_rdata | output | 8 | Byte-register read data, combinational |
| dma_wr | input | 1 | DMA-word write strobe |
| dma_addr | input | 8 | DMA-word address (index in bits [3:2]) |
| dma_wdata | input | 32 | DMA-word write data |
| dma_rdata | output | 32 | DMA-word read data, combinational |
| irq | output | 1 | Interrupt request raised by select with attention |

## Verification
The assertions check a set of rules on every clock cycle:
- a chip reset leaves only the identification bit set in the whole byte bank;
- a select loads the three fixed status codes and raises the interrupt;
- the interrupt never drops except through a clear;
- a write to a guarded index, or an unknown or harmless command, leaves the bank unchanged;
- a DMA write lands in the decoded word.

Only the bench scenarios can show the address aliasing through the ignored address bits, the masking of command bit 7, and the readback value of the command port. They also show that storable bytes survive harmless commands and that a system reset restores the same image as a chip reset.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

    localparam int BYTE_W = 8;

    // Byte-register indices whose behaviour is fixed by the command set
    localparam int IDX_CMD  = 3;
    localparam int IDX_STAT = 4;
    localparam int IDX_INTR = 5;
    localparam int IDX_SEQ  = 6;
    localparam int IDX_ID   = 14;

    localparam logic [BYTE_W-1:0] ID_VALUE = 8'h04;
    localparam logic [BYTE_W-1:0] SEL_STAT = 8'h1A;
    localparam logic [BYTE_W-1:0] SEL_INTR = 8'h20;
    localparam logic [BYTE_W-1:0] SEL_SEQ  = 8'h04;

    typedef enum logic [6:0] {
        CMD_NOP      = 7'h00,
        CMD_CHIP_RST = 7'h02,
        CMD_BUS_RST  = 7'h03,
        CMD_SET_ATN  = 7'h1A,
        CMD_SEL_ATN  = 7'h42
    } cmd_code_e;

    typedef struct packed {
        logic chip_rst;
        logic sel_atn;
        logic unknown;
    } cmd_act_t;

    // True when a host write to index i stores its data
    function automatic logic host_storable(int i);
        return !(i == IDX_CMD || (i >= 4 && i <= 7) || i >= 9);
    endfunction

    function automatic logic [BYTE_W-1:0] reset_value(int i);
        return (i == IDX_ID) ? ID_VALUE : '0;
    endfunction

    // True for the indices that a select command loads
    function automatic logic sel_loaded(int i);
        return (i == IDX_STAT) || (i == IDX_INTR) || (i == IDX_SEQ);
    endfunction

    function automatic logic [BYTE_W-1:0] sel_value(int i);
        case (i)
            IDX_STAT: return SEL_STAT;
            IDX_INTR: return SEL_INTR;
            IDX_SEQ:  return SEL_SEQ;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
    import scsi_ctl_pkg::*;
#(
    parameter int REG_IDX_W = 4
) (
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [6:0]           cmd_val,
    output cmd_act_t             act
);

    always_comb begin
        act = '0;
        if (wr_en && idx == REG_IDX_W'(IDX_CMD)) begin
            case (cmd_val)
                CMD_NOP, CMD_BUS_RST, CMD_SET_ATN: begin
                end
                CMD_CHIP_RST: act.chip_rst = 1'b1;
                CMD_SEL_ATN:  act.sel_atn  = 1'b1;
                default:      act.unknown  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/scsi_byte_regs.sv
module scsi_byte_regs
    import scsi_ctl_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    localparam int NUM_REGS = 1 << REG_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [BYTE_W-1:0]    wdata,
    input  cmd_act_t             act,
    output logic [BYTE_W-1:0]    rdata
);

    logic [NUM_REGS-1:0][BYTE_W-1:0] mem;
    logic                            clear;

    assign clear = rst || act.chip_rst;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic              KEEP = host_storable(i);
        localparam logic              LOAD = sel_loaded(i);
        localparam logic [BYTE_W-1:0] RVAL = reset_value(i);
        localparam logic [BYTE_W-1:0] SVAL = sel_value(i);

        if (KEEP) begin : g_rw
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (clear)
                    q <= RVAL;
                else if (wr_en && idx == REG_IDX_W'(i))
                    q <= wdata;
            end
            assign mem[i] = q;
        end else if (LOAD) begin : g_stat
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (clear)
                    q <= RVAL;
                else if (act.sel_atn)
                    q <= SVAL;
            end
            assign mem[i] = q;
        end else begin : g_fixed
            assign mem[i] = RVAL;
        end
    end

    assign rdata = mem[idx];

    // R5
    chip_rst_image_chk: assert property (@(posedge clk) disable iff (rst)
        act.chip_rst |=> ($countones(mem) == 1 && mem[IDX_ID] == ID_VALUE));

    // R6
    sel_status_chk: assert property (@(posedge clk) disable iff (rst)
        act.sel_atn |=> (mem[IDX_STAT] == SEL_STAT && mem[IDX_INTR] == SEL_INTR
                         && mem[IDX_SEQ] == SEL_SEQ));

    // R7 (also covers the harmless commands of R4)
    ro_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !host_storable(int'(idx)) && !act.chip_rst && !act.sel_atn)
        |=> $stable(mem));

    // R9
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        act.unknown |=> $stable(mem));

endmodule

// File: rtl/scsi_irq_ctl.sv
module scsi_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            irq <= 1'b0;
        else if (set)
            irq <= 1'b1;
    end

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> irq);

endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs #(
    parameter int DMA_W    = 32,
    parameter int DMA_REGS = 4,
    localparam int DIDX_W  = $clog2(DMA_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DIDX_W-1:0] idx,
    input  logic [DMA_W-1:0]  wdata,
    output logic [DMA_W-1:0]  rdata
);

    logic [DMA_REGS-1:0][DMA_W-1:0] words;

    always_ff @(posedge clk) begin
        if (rst || clr)
            words <= '0;
        else if (wr_en)
            words[idx] <= wdata;
    end

    assign rdata = words[idx];

    // R10
    dma_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> words[$past(idx)] == $past(wdata));

    // R5
    dma_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> words == '0);

endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
    import scsi_ctl_pkg::*;
#(
    parameter int HOST_AW   = 8,
    parameter int REG_IDX_W = 4,
    parameter int DMA_W     = 32,
    parameter int DMA_REGS  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [HOST_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    input  logic               dma_wr,
    input  logic [HOST_AW-1:0] dma_addr,
    input  logic [DMA_W-1:0]   dma_wdata,
    output logic [DMA_W-1:0]   dma_rdata,
    output logic               irq
);

    localparam int DIDX_W = $clog2(DMA_REGS);

    logic [REG_IDX_W-1:0] reg_idx;
    logic [DIDX_W-1:0]    dma_idx;
    cmd_act_t             act;
    logic                 unused_addr_bits;

    // Word stride: the low two address bits never select a register
    assign reg_idx = reg_addr[REG_IDX_W+1:2];
    assign dma_idx = dma_addr[DIDX_W+1:2];

    assign unused_addr_bits = ^{reg_addr[HOST_AW-1:REG_IDX_W+2], reg_addr[1:0],
                                dma_addr[HOST_AW-1:DIDX_W+2], dma_addr[1:0]};

    scsi_cmd_decode #(.REG_IDX_W(REG_IDX_W)) u_decode (
        .wr_en   (reg_wr),
        .idx     (reg_idx),
        .cmd_val (reg_wdata[6:0]),
        .act     (act)
    );

    scsi_byte_regs #(.REG_IDX_W(REG_IDX_W)) u_bytes (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .act   (act),
        .rdata (reg_rdata)
    );

    scsi_irq_ctl u_irq (
        .clk (clk),
        .rst (rst),
        .set (act.sel_atn),
        .clr (act.chip_rst),
        .irq (irq)
    );

    scsi_dma_regs #(.DMA_W(DMA_W), .DMA_REGS(DMA_REGS)) u_dma (
        .clk   (clk),
        .rst   (rst),
        .clr   (act.chip_rst),
        .wr_en (dma_wr),
        .idx   (dma_idx),
        .wdata (dma_wdata),
        .rdata (dma_rdata)
    );

endmodule

// File: tb/scsi_ctl_regs_tb.sv
`timescale 1ns/1ps
module scsi_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        dma_wr;
    logic [7:0]  dma_addr;
    logic [31:0] dma_wdata;
    logic [31:0] dma_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0]  model [16];
    logic [31:0] dmod  [4];

    always #4 clk = ~clk;

    scsi_ctl_regs u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_wr(dma_wr), .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .irq(irq)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[14] = 8'h04;
        for (int i = 0; i < 4; i++) dmod[i] = '0;
    endtask

    task automatic host_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic dma_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        dma_wr = 1'b1; dma_addr = a; dma_wdata = d;
        @(negedge clk);
        dma_wr = 1'b0;
    endtask

    task automatic check_bytes(string req);
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            reg_addr = 8'(i * 4);
            #1;
            chk(req, $sformatf("byte reg %0d", i), {24'h0, reg_rdata}, {24'h0, model[i]});
        end
    endtask

    task automatic check_dma(string req);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            dma_addr = 8'(i * 4);
            #1;
            chk(req, $sformatf("dma word %0d", i), dma_rdata, dmod[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic t_reset_state();
        check_bytes("R1");
        chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
        check_dma("R1");
    endtask

    task automatic t_store();
        host_wr(8'h00, 8'h11); model[0] = 8'h11;
        host_wr(8'h04, 8'h22); model[1] = 8'h22;
        host_wr(8'h08, 8'h33); model[2] = 8'h33;
        host_wr(8'h20, 8'h88); model[8] = 8'h88;
        check_bytes("R7");
    endtask

    task automatic t_readonly();
        for (int i = 4; i < 16; i++)
            if (i != 8) host_wr(8'(i * 4), 8'hFF);
        check_bytes("R7");
    endtask

    task automatic t_addr_decode();
        host_wr(8'hC4, 8'h5A); model[1] = 8'h5A;   // bits [7:6] set, index 1
        host_wr(8'h23, 8'hA5); model[8] = 8'hA5;   // bits [1:0] set, index 8
        check_bytes("R2");
        @(negedge clk);
        reg_addr = 8'h87;
        #1;
        chk("R2", "alias read of index 1", {24'h0, reg_rdata}, 32'h5A);
    endtask

    task automatic t_benign_cmds();
        host_wr(8'h0C, 8'h00);
        host_wr(8'h0C, 8'h03);
        host_wr(8'h0C, 8'h1A);
        host_wr(8'h0C, 8'h83);
        check_bytes("R4");
        chk("R4", "irq after harmless commands", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_unknown_cmds();
        host_wr(8'h0C, 8'h11);
        host_wr(8'h0C, 8'h7F);
        host_wr(8'h0C, 8'h40);
        check_bytes("R9");
        chk("R9", "irq after unknown commands", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_dma();
        dma_write(8'h00, 32'hDEAD_0000); dmod[0] = 32'hDEAD_0000;
        dma_write(8'h04, 32'h1111_2222); dmod[1] = 32'h1111_2222;
        dma_write(8'h08, 32'h3333_4444); dmod[2] = 32'h3333_4444;
        dma_write(8'h0C, 32'h5555_6666); dmod[3] = 32'h5555_6666;
        check_dma("R10");
        dma_write(8'hF1, 32'hCAFE_F00D); dmod[0] = 32'hCAFE_F00D; // aliases index 0
        dma_write(8'h1E, 32'h0BAD_BEEF); dmod[3] = 32'h0BAD_BEEF; // aliases index 3
        check_dma("R10");
    endtask

    task automatic t_select();
        host_wr(8'h0C, 8'h42);
        model[4] = 8'h1A; model[5] = 8'h20; model[6] = 8'h04;
        chk("R6", "irq right after select", {31'h0, irq}, 32'h1);
        check_bytes("R6");
    endtask

    task automatic t_irq_hold();
        host_wr(8'h10, 8'h00);    // guarded status byte
        host_wr(8'h0C, 8'h00);
        host_wr(8'h0C, 8'h1A);
        host_wr(8'h0C, 8'h55);
        chk("R8", "irq held after other commands", {31'h0, irq}, 32'h1);
        check_bytes("R7");
    endtask

    task automatic t_chip_reset_bit7();
        host_wr(8'h0C, 8'h82);
        model_reset();
        chk("R3", "irq after masked chip reset", {31'h0, irq}, 32'h0);
        check_bytes("R5");
        check_dma("R5");
    endtask

    task automatic t_select_bit7();
        host_wr(8'h0C, 8'hC2);
        model[4] = 8'h1A; model[5] = 8'h20; model[6] = 8'h04;
        chk("R3", "irq after masked select", {31'h0, irq}, 32'h1);
        check_bytes("R3");
        host_wr(8'h0C, 8'h02);
        model_reset();
        chk("R5", "irq after chip reset", {31'h0, irq}, 32'h0);
        check_bytes("R5");
    endtask

    task automatic t_sys_reset();
        host_wr(8'h00, 8'h77);
        dma_write(8'h08, 32'h1234_5678);
        host_wr(8'h0C, 8'h42);
        chk("R6", "irq before system reset", {31'h0, irq}, 32'h1);
        do_reset();
        chk("R8", "irq cleared by system reset", {31'h0, irq}, 32'h0);
        check_bytes("R1");
        check_dma("R1");
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        dma_wr = 1'b0; dma_addr = '0; dma_wdata = '0;
        model_reset();
        do_reset();
        t_reset_state();
        t_store();
        t_readonly();
        t_addr_decode();
        t_benign_cmds();
        t_unknown_cmds();
        t_dma();
        t_select();
        t_irq_hold();
        t_chip_reset_bit7();
        t_select_bit7();
        t_sys_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule